// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with an 18-bit address. The host raises a one-cycle request carrying an address, a direction flag and, for a write, a data byte. The controller then drives the active-low chip, output and write enables, the address lines and a split data bus (outgoing byte, drive enable, incoming byte) for a pad tristate. It answers with a one-cycle done pulse and, for a read, the captured byte.

Every phase is a whole number of system clock cycles set by a parameter: read access, write address setup, write pulse and bus turnaround. The integrator picks them from the memory's nanosecond limits and the clock period. Writes are framed by chip enable and write enable both low while output enable stays high. When the transfer direction changes, the controller inserts idle cycles with no enable low and no driver, so the controller and the memory never drive the bus together. Between requests the chip enable is high and the memory rests in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and after it until a request arrives, chip, output and write enable are all 1, the bus drive enable is 0, and busy and done are 0.
- R2: Whenever busy is 0, chip enable is 1 (standby).
- R3: A read holds chip enable 0, output enable 0, write enable 1 and drive enable 0 for exactly RD_CYC cycles. The byte present on the incoming bus at the clock edge that ends that window appears on rd_data and stays there until the next read.
- R4: Each accepted request gives exactly one done pulse, one cycle wide. A read's pulse comes in the cycle after its access window; a write's pulse comes in the cycle after write enable rises.
- R5: While write enable is 0, chip enable is 0, output enable is 1 and the bus is driven.
- R6: A write drives the address and data with chip enable 0 for WR_SETUP_CYC cycles before write enable falls. Write enable then stays 0 for exactly WR_PULSE_CYC cycles. Address and data hold through the pulse and for one cycle after it.
- R7: When a read follows a write or a write follows a read, TURN_CYC cycles with all enables 1 and no driver come before the new operation. The controller never drives in a cycle where output enable is 0, nor in the cycle right after one.
- R8: A request is accepted only while busy is 0. A request raised while busy is 1, including in the done cycle, is dropped and starts no memory cycle.
- R9: Busy is 1 from the cycle after acceptance through the done cycle.
- R10: With the same direction as the previous operation, the first phase starts in the cycle right after acceptance. The done pulse then arrives RD_CYC+1 cycles (read) or WR_SETUP_CYC+WR_PULSE_CYC+1 cycles (write) after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last byte read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_out | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Byte received from the memory |

## Verification
Two things can land in the same cycle: the done pulse of one operation and the host's next request. That request must be dropped, because busy is still 1. The bench raises a write request in exactly the done cycle of a read, and also during the read's access window. It then checks that busy stays low and no memory cycle follows, and that reading the target address back still returns the scoreboard value. A direction change can also meet acceptance in one cycle. Measured done latencies show that the turnaround cycles are inserted only on a direction change. A bus monitor in the memory model flags any overlap of the two drivers.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_RD_CAP,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOV,
      ST_TURN
   } ctrl_state_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drive;
   } pin_ctl_t;

   // Pin levels for each state; outputs are registered from this decode
   function automatic pin_ctl_t decode_pins(ctrl_state_t s);
      pin_ctl_t p;
      p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      case (s)
         ST_RD_ACC:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
         ST_WR_SETUP: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
         ST_WR_PULSE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
         ST_WR_RECOV: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
         default:     p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // Phase length depends on a strict one-per-cycle countdown
   assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (en)  q <= d;
   end

   assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int DATA_W       = 8,
   parameter int RD_CYC       = 2,
   parameter int WR_SETUP_CYC = 1,
   parameter int WR_PULSE_CYC = 2,
   parameter int TURN_CYC     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int MAX_AB  = (RD_CYC > WR_SETUP_CYC) ? RD_CYC : WR_SETUP_CYC;
   localparam int MAX_CD  = (WR_PULSE_CYC > TURN_CYC) ? WR_PULSE_CYC : TURN_CYC;
   localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] LD_WS   = CNT_W'(WR_SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WR_PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

   generate
      if (RD_CYC < 1 || WR_SETUP_CYC < 1 || WR_PULSE_CYC < 1 || TURN_CYC < 1) begin : g_bad_phase
         $error("every phase length must be at least one cycle");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("address and data widths must be positive");
      end
   endgenerate

   ctrl_state_t       state_q, state_d;
   pin_ctl_t          pins_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              op_we_q;
   logic              prev_valid_q, prev_we_q;
   logic              busy_q, done_q;
   logic              accept, cap_en, t_load, t_expired;
   logic [CNT_W-1:0]  t_val;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cap_en),
      .d     (mem_dq_in),
      .q     (rd_data)
   );

   always_comb begin
      state_d = state_q;
      accept  = 1'b0;
      cap_en  = 1'b0;
      t_load  = 1'b0;
      t_val   = '0;
      case (state_q)
         ST_IDLE: begin
            if (req) begin
               accept = 1'b1;
               t_load = 1'b1;
               if (prev_valid_q && (prev_we_q != req_we)) begin
                  state_d = ST_TURN;
                  t_val   = LD_TURN;
               end else if (req_we) begin
                  state_d = ST_WR_SETUP;
                  t_val   = LD_WS;
               end else begin
                  state_d = ST_RD_ACC;
                  t_val   = LD_RD;
               end
            end
         end
         ST_TURN: begin
            if (t_expired) begin
               t_load  = 1'b1;
               state_d = op_we_q ? ST_WR_SETUP : ST_RD_ACC;
               t_val   = op_we_q ? LD_WS : LD_RD;
            end
         end
         ST_RD_ACC: begin
            if (t_expired) begin
               cap_en  = 1'b1;
               state_d = ST_RD_CAP;
            end
         end
         ST_WR_SETUP: begin
            if (t_expired) begin
               t_load  = 1'b1;
               t_val   = LD_WP;
               state_d = ST_WR_PULSE;
            end
         end
         ST_WR_PULSE: begin
            if (t_expired) state_d = ST_WR_RECOV;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pins_q       <= decode_pins(ST_IDLE);
         busy_q       <= 1'b0;
         done_q       <= 1'b0;
         addr_q       <= '0;
         wdata_q      <= '0;
         op_we_q      <= 1'b0;
         prev_valid_q <= 1'b0;
         prev_we_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         pins_q  <= decode_pins(state_d);
         busy_q  <= (state_d != ST_IDLE);
         done_q  <= (state_d == ST_RD_CAP) || (state_d == ST_WR_RECOV);
         if (accept) begin
            addr_q       <= req_addr;
            wdata_q      <= req_wdata;
            op_we_q      <= req_we;
            prev_valid_q <= 1'b1;
            prev_we_q    <= req_we;
         end
      end
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign mem_ce_n   = pins_q.ce_n;
   assign mem_oe_n   = pins_q.oe_n;
   assign mem_we_n   = pins_q.we_n;
   assign mem_dq_oe  = pins_q.drive;
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   assert_standby_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> mem_ce_n);

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_write_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   assert_pulse_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   assert_no_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   assert_release_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mem_oe_n) |-> !mem_dq_oe);

   assert_busy_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_addr));

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

   localparam int AW = 18;
   localparam int DW = 8;
   localparam int RD = 3;
   localparam int WS = 1;
   localparam int WP = 2;
   localparam int TA = 2;
   localparam int NVEC = 12;

   // {write, address, data}
   localparam logic [AW+DW:0] VEC [NVEC] = '{
      {1'b1, 18'h00010, 8'h3C},
      {1'b1, 18'h3FFFF, 8'hA5},
      {1'b0, 18'h00010, 8'h00},
      {1'b0, 18'h3FFFF, 8'h00},
      {1'b1, 18'h00000, 8'hFF},
      {1'b0, 18'h00000, 8'h00},
      {1'b1, 18'h20001, 8'h5A},
      {1'b1, 18'h00010, 8'h81},
      {1'b0, 18'h20001, 8'h00},
      {1'b0, 18'h00010, 8'h00},
      {1'b0, 18'h12345, 8'h00},
      {1'b1, 18'h12345, 8'h07}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy, done;
   logic [DW-1:0] rd_data;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD),
      .WR_SETUP_CYC(WS), .WR_PULSE_CYC(WP), .TURN_CYC(TA)
   ) i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // ---------------- behavioural memory model ----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] sb  [int];
   int rd_cnt = 0, we_cnt = 0, setup_cnt = 0;
   int bad_wr = 0, clash = 0, idle_err = 0, done_err = 0;
   logic prev_ovl = 1'b0, prev_mdrv = 1'b0, prev_dqoe = 1'b0, prev_done = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_data = '0;
   logic mdrv;

   function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 8'h00;
   endfunction

   assign mdrv = !mem_ce_n && !mem_oe_n && mem_we_n;

   always_comb begin
      if (mdrv && rd_cnt >= RD) mem_dq_in = mem_rd(mem_addr);
      else                      mem_dq_in = 8'hC3;
   end

   always @(negedge clk) begin
      logic ovl;
      ovl = !mem_ce_n && !mem_we_n;
      if (mdrv) rd_cnt = rd_cnt + 1; else rd_cnt = 0;
      if (ovl) begin
         if (!prev_ovl && setup_cnt != WS) bad_wr = bad_wr + 1;
         we_cnt = we_cnt + 1;
         if (!mem_oe_n || !mem_dq_oe) bad_wr = bad_wr + 1;
         if (prev_ovl && (mem_dq_out != prev_data || mem_addr != prev_addr)) bad_wr = bad_wr + 1;
      end else begin
         if (prev_ovl) begin
            mem[int'(prev_addr)] = prev_data;
            if (we_cnt != WP) bad_wr = bad_wr + 1;
            if (!mem_dq_oe || mem_dq_out != prev_data || mem_addr != prev_addr) bad_wr = bad_wr + 1;
         end
         we_cnt = 0;
      end
      if (mem_dq_oe && !mem_ce_n && !ovl) setup_cnt = setup_cnt + 1;
      else if (!mem_dq_oe) setup_cnt = 0;
      if (mdrv && mem_dq_oe)      clash = clash + 1;
      if (prev_mdrv && mem_dq_oe) clash = clash + 1;
      if (prev_dqoe && mdrv)      clash = clash + 1;
      if (rst_n && !busy && !mem_ce_n) idle_err = idle_err + 1;
      if (done && prev_done)      done_err = done_err + 1;
      prev_ovl  = ovl;
      prev_mdrv = mdrv;
      prev_dqoe = mem_dq_oe;
      prev_done = done;
      prev_addr = mem_addr;
      prev_data = mem_dq_out;
   end

   // ---------------- host side ----------------
   logic have_prev = 1'b0;
   logic prev_dir  = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int lat, exp_lat;
      logic [DW-1:0] exp_rd;
      logic turn;
      turn    = have_prev && (prev_dir != we);
      exp_lat = (we ? (WS + WP + 1) : (RD + 1)) + (turn ? TA : 0);
      exp_rd  = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 1'b0;
      lat = 1;
      check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
      while (!done && lat < 100) begin
         @(negedge clk);
         lat = lat + 1;
      end
      if (turn) check(lat == exp_lat, "R7 turnaround latency", lat, exp_lat);
      else      check(lat == exp_lat, "R10 direct latency", lat, exp_lat);
      if (!we) check(rd_data == exp_rd, "R3 read data", int'(rd_data), int'(exp_rd));
      else     sb[int'(a)] = d;
      @(negedge clk);
      check(done == 1'b0, "R4 done one cycle", int'(done), 0);
      while (busy) @(negedge clk);
      have_prev = 1'b1;
      prev_dir  = we;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done} == 6'b111000,
            "R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done}, 6'b111000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy} == 5'b11100,
            "R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy}, 5'b11100);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][AW+DW], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      end

      // R8: requests during busy and in the done cycle are dropped
      begin
         int guard;
         @(negedge clk);
         req = 1'b1; req_we = 1'b0; req_addr = 18'h00010;
         @(negedge clk);
         req = 1'b1; req_we = 1'b1; req_addr = 18'h3FFFF; req_wdata = 8'hEE;
         guard = 0;
         while (!done && guard < 50) begin
            @(negedge clk);
            guard = guard + 1;
         end
         check(rd_data == sb[int'(18'h00010)], "R3 read under busy request",
               int'(rd_data), int'(sb[int'(18'h00010)]));
         // req stays high through the done cycle, then drops
         @(negedge clk);
         req = 1'b0;
         check(busy == 1'b0, "R8 no accept at done", int'(busy), 0);
         repeat (4) begin
            @(negedge clk);
            check(busy == 1'b0 && mem_ce_n == 1'b1, "R8 dropped request idle",
                  {busy, mem_ce_n}, 2'b01);
         end
         prev_dir = 1'b0;
         run_op(1'b0, 18'h3FFFF, 8'h00);
      end

      // Random mixed sequence over a small address pool
      for (int k = 0; k < 150; k++) begin
         logic [AW-1:0] a;
         a = AW'(18'h01000 + (($urandom % 8) * 18'h0811));
         run_op(1'($urandom % 2), a, 8'($urandom));
      end

      // Mid-operation reset forces enables high and driver off
      @(negedge clk);
      req = 1'b1; req_we = 1'b1; req_addr = 18'h00777; req_wdata = 8'h99;
      @(negedge clk);
      req = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy} == 5'b11100,
            "R1 reset mid write", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy}, 5'b11100);
      rst_n = 1'b1;
      have_prev = 1'b0;
      run_op(1'b0, 18'h00010, 8'h00);

      // Monitor totals
      check(clash == 0,    "R7 bus overlap count", clash, 0);
      check(bad_wr == 0,   "R5 R6 write framing errors", bad_wr, 0);
      check(idle_err == 0, "R2 standby violations", idle_err, 0);
      check(done_err == 0, "R4 done width errors", done_err, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule